// File: doc/BRIEF.md
# Qualified Capture Trigger Controller

This block is the control core of an on-chip logic analyzer. Each cycle it receives a vector of match flags from external comparator units together with one data sample. A programmable trigger sequencer of up to four ordered stages decides when the trigger event happens. A second, independent equation decides, sample by sample, whether the current sample is worth storing. Only samples that pass this qualification are written into a circular capture memory through a simple write port.

The trigger can sit anywhere in the capture window. Software programs how many qualified samples should precede it. After the trigger, the controller keeps storing qualified samples until the rest of the window is full. It then raises a completion flag and holds the memory address at which the trigger happened. An arm strobe starts a new capture.

A trigger output pin follows the trigger event after a fixed delay. It can drive external instruments, an interrupt line or another analyzer. At runtime it can be set as a one-cycle pulse or as a held level, and as active-high or active-low.

Top module: `qcap_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, `done_o` is 0 and `mem_we_o` is 0. `trig_out_o` then equals `out_low_i`, which is the inactive level.
- R2: Each stage equation and the qualification equation take the match flags selected by their mask. In AND mode (op bit 0) the equation is true when all selected flags are 1, so an all-zero mask is always true. In OR mode (op bit 1) it is true when any selected flag is 1, so an all-zero mask is never true. Stage k uses mask bits `[k*NM +: NM]` and op bit `stage_or_i[k]`.
- R3: After an arm, the sequencer starts at stage 0. While stage k (k below `last_stage_i`) is current and its equation holds, it moves to stage k+1 at the next edge. The trigger fires in the cycle in which stage `last_stage_i` is current and its equation holds.
- R4: While capturing (from the cycle after an arm until done), a sample is written exactly in the cycles where the qualification equation holds. `mem_addr_o` starts at 0 after an arm and advances by one, modulo 2^AW, only after a write. `mem_data_o` carries `sample_i`.
- R5: The trigger cycle is the first post-trigger cycle. `done_o` rises at the edge after the qualified write that brings the post-trigger write count to 2^AW − `pretrig_i`. When `pretrig_i` ≥ 2^AW, `done_o` rises at the edge after the trigger cycle, and nothing is written in that cycle. `done_o` stays high until the next arm.
- R6: While `done_o` is high, `trig_addr_o` holds the value that `mem_addr_o` had in the trigger cycle.
- R7: No write happens while idle, while done, or in an arm cycle.
- R8: If the trigger fires in cycle t, `trig_out_o` shows the active level from cycle t+10.
- R9: With `out_level_i` = 0 (pulse mode), the active level lasts exactly one cycle.
- R10: With `out_level_i` = 1 (level mode), the active level stays from cycle t+10 until the next arm.
- R11: With `out_low_i` = 1, the pin is inverted, so the active level is 0.
- R12: An arm strobe clears `done_o`, the sequencer stage, the write address, the post-trigger count and the trigger output state. Capture then restarts from the next cycle, even if a capture is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Start or restart a capture |
| match_i | input | NM | Flags from the match units |
| sample_i | input | DW | Sample data |
| stage_mask_i | input | NS*NM | Per-stage flag selection |
| stage_or_i | input | NS | Per-stage op: 0 AND, 1 OR |
| last_stage_i | input | SW | Index of the final sequencer stage |
| qual_mask_i | input | NM | Qualification flag selection |
| qual_or_i | input | 1 | Qualification op: 0 AND, 1 OR |
| pretrig_i | input | AW+1 | Qualified samples kept before the trigger |
| out_level_i | input | 1 | Trigger pin shape: 0 pulse, 1 level |
| out_low_i | input | 1 | Trigger pin polarity: 1 active-low |
| mem_we_o | output | 1 | Capture memory write enable |
| mem_addr_o | output | AW | Capture memory write address |
| mem_data_o | output | DW | Capture memory write data |
| done_o | output | 1 | Capture window complete |
| trig_addr_o | output | AW | Write address at the trigger cycle |
| trig_out_o | output | 1 | Delayed, shaped trigger pin |

## Verification
The bench targets the trigger at both window ends. With `pretrig_i` = 0, a controller that ignores the trigger cycle's own sample finishes one write late. With `pretrig_i` = 2^AW, a design that writes the trigger sample anyway overruns the window. The bench runs a four-stage sequence that mixes AND and OR stages. This exposes a sequencer that skips stages or fires on a stale stage. The bench also re-arms mid-capture, where a design that keeps its address, count or a trigger pulse still in the delay line produces a stray write address or pin edge. Level and pulse shapes are each checked in both polarities. An off-by-one in the ten-cycle delay shows up as a pin edge one cycle early or late.

// File: rtl/qcap_pkg.sv
package qcap_pkg;

    localparam int TRIG_LAT = 10;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_PRE  = 2'd1,
        CAP_POST = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic pulse;
        logic held;
    } pin_state_t;

    function automatic logic shape_pin(pin_state_t ps, logic level_mode, logic active_low);
        return (ps.pulse | (level_mode & ps.held)) ^ active_low;
    endfunction

endpackage

// File: rtl/qcap_eq.sv
module qcap_eq #(
    parameter int NM = 6
) (
    input  logic [NM-1:0] flags_i,
    input  logic [NM-1:0] mask_i,
    input  logic          or_i,
    output logic          hit_o
);
    logic [NM-1:0] sel;

    always_comb begin
        sel   = flags_i & mask_i;
        hit_o = or_i ? (|sel) : (sel == mask_i);
    end
endmodule

// File: rtl/qcap_seq.sv
module qcap_seq #(
    parameter int NS = 4,
    parameter int SW = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_i,
    input  logic          armed_i,
    input  logic [NS-1:0] hit_i,
    input  logic [SW-1:0] last_i,
    output logic          fire_o
);
    logic [SW-1:0] stage_q;
    logic          cur_hit;
    logic          at_last;

    always_comb begin
        cur_hit = hit_i[stage_q];
        at_last = (stage_q == last_i);
        fire_o  = armed_i && !arm_i && cur_hit && at_last;
    end

    always_ff @(posedge clk) begin
        if (rst || arm_i) begin
            stage_q <= '0;
        end else if (armed_i && cur_hit && !at_last) begin
            stage_q <= stage_q + SW'(1);
        end
    end
endmodule

// File: rtl/qcap_fsm.sv
module qcap_fsm
    import qcap_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_i,
    input  logic          fire_i,
    input  logic          qual_i,
    input  logic [AW:0]   post_len_i,
    output logic          armed_o,
    output logic          we_o,
    output logic [AW-1:0] wptr_o,
    output logic          done_o,
    output logic [AW-1:0] taddr_o
);
    cap_state_e    st_q;
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] taddr_q;
    logic [AW:0]   cnt_q;
    logic          capturing, skip, counting, inc, reach;

    always_comb begin
        capturing = (st_q == CAP_PRE) || (st_q == CAP_POST);
        skip      = fire_i && (post_len_i == '0);
        we_o      = !arm_i && capturing && qual_i && !skip;
        counting  = fire_i || (st_q == CAP_POST);
        inc       = counting && we_o;
        reach     = skip || (inc && (cnt_q + (AW+1)'(1) == post_len_i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= CAP_IDLE;
            wptr_q  <= '0;
            cnt_q   <= '0;
            taddr_q <= '0;
        end else if (arm_i) begin
            st_q   <= CAP_PRE;
            wptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (we_o)   wptr_q  <= wptr_q + AW'(1);
            if (inc)    cnt_q   <= cnt_q + (AW+1)'(1);
            if (fire_i) taddr_q <= wptr_q;
            if (reach)       st_q <= CAP_DONE;
            else if (fire_i) st_q <= CAP_POST;
        end
    end

    assign armed_o = (st_q == CAP_PRE);
    assign done_o  = (st_q == CAP_DONE);
    assign wptr_o  = wptr_q;
    assign taddr_o = taddr_q;
endmodule

// File: rtl/qcap_shaper.sv
module qcap_shaper
    import qcap_pkg::*;
#(
    parameter int LAT = TRIG_LAT
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic fire_i,
    input  logic level_i,
    input  logic low_i,
    output logic pin_o
);
    logic [LAT-1:0] dly_q;
    logic           held_q;
    pin_state_t     ps;

    always_ff @(posedge clk) begin
        if (rst || arm_i) begin
            dly_q  <= '0;
            held_q <= 1'b0;
        end else begin
            dly_q  <= {dly_q[LAT-2:0], fire_i};
            held_q <= held_q | dly_q[LAT-1];
        end
    end

    always_comb begin
        ps.pulse = dly_q[LAT-1];
        ps.held  = held_q;
        pin_o    = shape_pin(ps, level_i, low_i);
    end
endmodule

// File: rtl/qcap_ctrl.sv
module qcap_ctrl
    import qcap_pkg::*;
#(
    parameter int NM  = 6,
    parameter int DW  = 16,
    parameter int AW  = 5,
    parameter int NS  = 4,
    parameter int SW  = $clog2(NS),
    parameter int LAT = TRIG_LAT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic [NM-1:0]    match_i,
    input  logic [DW-1:0]    sample_i,
    input  logic [NS*NM-1:0] stage_mask_i,
    input  logic [NS-1:0]    stage_or_i,
    input  logic [SW-1:0]    last_stage_i,
    input  logic [NM-1:0]    qual_mask_i,
    input  logic             qual_or_i,
    input  logic [AW:0]      pretrig_i,
    input  logic             out_level_i,
    input  logic             out_low_i,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_data_o,
    output logic             done_o,
    output logic [AW-1:0]    trig_addr_o,
    output logic             trig_out_o
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

    logic [NS-1:0] stage_hit;
    logic          qual_hit;
    logic          fire;
    logic          armed;
    logic [AW:0]   post_len;

    for (genvar g = 0; g < NS; g++) begin : g_stage
        qcap_eq #(.NM(NM)) u_eq (
            .flags_i (match_i),
            .mask_i  (stage_mask_i[g*NM +: NM]),
            .or_i    (stage_or_i[g]),
            .hit_o   (stage_hit[g])
        );
    end

    qcap_eq #(.NM(NM)) u_qual (
        .flags_i (match_i),
        .mask_i  (qual_mask_i),
        .or_i    (qual_or_i),
        .hit_o   (qual_hit)
    );

    always_comb post_len = (pretrig_i >= DEPTH_W) ? '0 : DEPTH_W - pretrig_i;

    qcap_seq #(.NS(NS), .SW(SW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (arm_i),
        .armed_i (armed),
        .hit_i   (stage_hit),
        .last_i  (last_stage_i),
        .fire_o  (fire)
    );

    qcap_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (arm_i),
        .fire_i     (fire),
        .qual_i     (qual_hit),
        .post_len_i (post_len),
        .armed_o    (armed),
        .we_o       (mem_we_o),
        .wptr_o     (mem_addr_o),
        .done_o     (done_o),
        .taddr_o    (trig_addr_o)
    );

    qcap_shaper #(.LAT(LAT)) u_pin (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (arm_i),
        .fire_i  (fire),
        .level_i (out_level_i),
        .low_i   (out_low_i),
        .pin_o   (trig_out_o)
    );

    assign mem_data_o = sample_i;
endmodule

// File: rtl/qcap_chk.sv
module qcap_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          arm_i,
    input logic          out_level_i,
    input logic          out_low_i,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          done_o,
    input logic          trig_out_o
);
    logic act;
    assign act = trig_out_o ^ out_low_i;

    assert_no_write_when_done_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_we_o);

    assert_addr_steps_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && !arm_i) |=> (mem_addr_o == AW'($past(mem_addr_o) + AW'(1))));

    assert_addr_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_o && !arm_i) |=> $stable(mem_addr_o));

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !arm_i) |=> done_o);

    assert_arm_restarts_R12: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (!done_o && mem_addr_o == '0 && !act));

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
        (act && !out_level_i && !arm_i) |=> (!act || out_level_i));

    assert_level_held_R10: assert property (@(posedge clk) disable iff (rst)
        (act && out_level_i && !arm_i) |=> (act || !out_level_i));
endmodule

bind qcap_ctrl qcap_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .arm_i       (arm_i),
    .out_level_i (out_level_i),
    .out_low_i   (out_low_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .done_o      (done_o),
    .trig_out_o  (trig_out_o)
);

// File: tb/qcap_ctrl_tb.sv
module qcap_ctrl_tb;
    localparam int NM = 6, DW = 16, AW = 5, NS = 4, SW = 2;
    localparam int DEPTH = 1 << AW;
    localparam int LAT = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0;
    logic [NM-1:0] match = '0;
    logic [DW-1:0] sample = '0;
    logic [NS*NM-1:0] smask = '0;
    logic [NS-1:0] sor = '0;
    logic [SW-1:0] last = '0;
    logic [NM-1:0] qmask = '0;
    logic qor = 1'b0;
    logic [AW:0] pretrig = '0;
    logic olevel = 1'b0, olow = 1'b0;

    logic mem_we_o, done_o, trig_out_o;
    logic [AW-1:0] mem_addr_o, trig_addr_o;
    logic [DW-1:0] mem_data_o;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    qcap_ctrl #(.NM(NM), .DW(DW), .AW(AW), .NS(NS)) u_dut (
        .clk(clk), .rst(rst), .arm_i(arm), .match_i(match), .sample_i(sample),
        .stage_mask_i(smask), .stage_or_i(sor), .last_stage_i(last),
        .qual_mask_i(qmask), .qual_or_i(qor), .pretrig_i(pretrig),
        .out_level_i(olevel), .out_low_i(olow),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
        .done_o(done_o), .trig_addr_o(trig_addr_o), .trig_out_o(trig_out_o)
    );

    // Behavioural reference model
    int m_st = 0, m_stage = 0, m_wptr = 0, m_cnt = 0, m_taddr = 0;
    bit m_lvl = 1'b0;
    bit m_hist[$];
    bit m_hit, m_fire, m_we, m_inc, m_reach;
    int m_post;

    function automatic bit eqf(input logic [NM-1:0] f, input logic [NM-1:0] m, input bit o);
        if (o) return |(f & m);
        return (f & m) == m;
    endfunction

    always_comb begin
        m_post  = (int'(pretrig) >= DEPTH) ? 0 : DEPTH - int'(pretrig);
        m_hit   = eqf(match, smask[m_stage*NM +: NM], sor[m_stage]);
        m_fire  = !arm && m_st == 1 && m_hit && m_stage == int'(last);
        m_we    = !arm && (m_st == 1 || m_st == 2) && eqf(match, qmask, qor)
                  && !(m_fire && m_post == 0);
        m_inc   = m_we && (m_fire || m_st == 2);
        m_reach = (m_fire && m_post == 0) || (m_inc && m_cnt + 1 == m_post);
    end

    always @(posedge clk) begin
        if (rst || arm) begin
            m_st    <= rst ? 0 : 1;
            m_stage <= 0;
            m_wptr  <= 0;
            m_cnt   <= 0;
            if (rst) m_taddr <= 0;
            m_lvl   <= 1'b0;
            m_hist.delete();
            for (int i = 0; i < LAT; i++) m_hist.push_back(1'b0);
        end else begin
            m_lvl <= m_lvl | m_hist[0];
            void'(m_hist.pop_front());
            m_hist.push_back(m_fire);
            if (m_we) m_wptr <= (m_wptr + 1) % DEPTH;
            if (m_inc) m_cnt <= m_cnt + 1;
            if (m_fire) m_taddr <= m_wptr;
            if (m_reach) m_st <= 3;
            else if (m_fire) m_st <= 2;
            if (m_st == 1 && m_hit && m_stage != int'(last)) m_stage <= m_stage + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string sc);
        bit eo;
        eo = (m_hist[0] | (olevel & m_lvl)) ^ olow;
        chk(mem_we_o === m_we, {"R4 R7 ", sc}, "mem_we", int'(mem_we_o), int'(m_we));
        chk(mem_addr_o === AW'(m_wptr), {"R4 ", sc}, "mem_addr", int'(mem_addr_o), m_wptr);
        if (m_we) chk(mem_data_o === sample, {"R4 ", sc}, "mem_data", int'(mem_data_o), int'(sample));
        chk(done_o === (m_st == 3), {"R5 ", sc}, "done", int'(done_o), int'(m_st == 3));
        if (m_st == 3) chk(trig_addr_o === AW'(m_taddr), {"R6 ", sc}, "trig_addr", int'(trig_addr_o), m_taddr);
        chk(trig_out_o === eo, {"R8 ", sc}, "trig_out", int'(trig_out_o), int'(eo));
    endtask

    task automatic step(input string sc);
        @(negedge clk);
        compare(sc);
    endtask

    task automatic run(input int n, input string sc);
        for (int i = 0; i < n; i++) begin
            step(sc);
            match  = NM'($urandom);
            sample = DW'($urandom);
        end
    endtask

    task automatic do_arm(input string sc);
        step(sc);
        arm = 1'b1;
        match = NM'($urandom);
        step(sc);
        arm = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < LAT; i++) m_hist.push_back(1'b0);
        repeat (3) step("R1 reset");
        rst = 1'b0;
        step("R1 reset");
        chk(done_o === 1'b0, "R1", "done after reset", int'(done_o), 0);
        chk(mem_we_o === 1'b0, "R1", "we after reset", int'(mem_we_o), 0);
        chk(trig_out_o === olow, "R1", "pin after reset", int'(trig_out_o), int'(olow));

        // One AND stage, qualification always true, trigger mid-window, pulse high
        smask = '0; smask[0 +: NM] = 6'b000011; sor = '0; last = 2'd0;
        qmask = '0; qor = 1'b0; pretrig = 6'd8; olevel = 1'b0; olow = 1'b0;
        run(5, "R7 idle");
        do_arm("R2 R9");
        run(120, "R2 R5 R9");
        chk(done_o === 1'b1, "R5", "done reached mid", int'(done_o), 1);

        // OR stage, OR qualification, trigger at window start, pulse active-low
        smask[0 +: NM] = 6'b110000; sor = 4'b0001;
        qmask = 6'b001100; qor = 1'b1; pretrig = 6'd0; olow = 1'b1;
        do_arm("R2 R11");
        run(200, "R2 R4 R11");
        chk(done_o === 1'b1, "R5", "done reached start", int'(done_o), 1);

        // Four ordered stages, trigger at window end, level active-low
        smask = {6'b100000, 6'b011000, 6'b000110, 6'b000001};
        sor = 4'b0100; last = 2'd3;
        qmask = 6'b000100; qor = 1'b0; pretrig = 6'd32; olevel = 1'b1; olow = 1'b1;
        do_arm("R3 R10");
        run(150, "R3 R5 R10 R11");
        chk(done_o === 1'b1, "R5", "done reached end", int'(done_o), 1);

        // Level active-high, then re-arm during capture with pulse shape
        olow = 1'b0; pretrig = 6'd31; qmask = '0;
        do_arm("R10 R12");
        run(60, "R10 R12");
        olevel = 1'b0; pretrig = 6'd4;
        do_arm("R12");
        run(12, "R9 R12");
        do_arm("R12 rearm");
        run(150, "R9 R12");
        chk(done_o === 1'b1, "R12", "done after rearm", int'(done_o), 1);

        // Qualification never true while capturing: nothing written
        qmask = '0; qor = 1'b1; last = 2'd0; smask[0 +: NM] = '0; sor = '0;
        do_arm("R4 R7");
        run(40, "R4 R7 noqual");
        chk(mem_addr_o === '0, "R4", "addr unchanged", int'(mem_addr_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule